// File: doc/BRIEF.md
# Receive FIFO Status and Interrupt Unit

This block handles the receive-side bookkeeping of a CAN-style message controller. It counts the frames waiting in a small receive queue. The oldest waiting frame is presented to the CPU as a foreground slot. The block keeps a receive-full flag, which means the foreground slot holds a frame, and a sticky overrun flag. When the CPU clears the full flag, the slot is released and the next queued frame moves forward one cycle later. No frame moves forward while the flag is set. Frame contents are not stored here: only occupancy, ring pointers and flags.

The block also holds an 8-bit interrupt-enable register. The bits are, from bit 7 down to bit 0: wakeup, status change, receiver-state field [1:0], transmitter-state field [1:0], overrun and receive-full. While initialization mode is active, this register is forced to its reset value, except for the two state fields. Two level interrupt outputs combine the flags with their enables.

Top module: `can_rx_flag_unit`

## Requirements
- R1: A `frame_ok_i` pulse sampled at a clock edge adds one occupied entry. If the full flag (flag register bit 0) is clear and at least one entry is occupied, the flag sets at the next edge. The flag is never set while no entry is occupied.
- R2: While the full flag is set and not being cleared, no entry moves forward: the flag stays set and the foreground slot index stays unchanged.
- R3: Writing 1 to flag register bit 0 while the flag is set clears the flag, frees one entry and advances the slot index. If entries remain, the flag sets again one edge later. Writing 0 to the bit has no effect.
- R4: The queue holds DEPTH entries, counting the foreground slot. A frame that arrives while all entries are occupied, with no release in the same cycle, is discarded and sets the overrun flag (flag register bit 1). A frame that arrives in the same cycle as a release is accepted.
- R5: The overrun flag is cleared by writing 1 to flag register bit 1. If a new overrun occurs in the same cycle as the clear, the flag stays set.
- R6: `irq_rx_o` is high exactly when the full flag is set and enable bit 0 is 1.
- R7: `irq_err_o` is high exactly when the overrun flag is set and enable bit 1 is 1.
- R8: The enable register (address 1) resets to 0x00. It reads back any value written while `init_req_i` and `init_ack_i` are both 0.
- R9: While `init_req_i` and `init_ack_i` are both 1, enable bits 7, 6, 1 and 0 are held at 0 and writes are ignored. Bits 5:2 keep their values.
- R10: While exactly one of `init_req_i` and `init_ack_i` is 1, writes to the enable register are ignored and its contents are not changed.
- R11: A read of address 2 while the full flag is set returns 0x80 OR the foreground slot index, where the index is the number of releases modulo DEPTH, with `cpu_err_o` low. While the flag is clear, the same read returns 0x00 with `cpu_err_o` high.
- R12: Address 0 reads the full flag in bit 0, overrun in bit 1 and zeros elsewhere. Address 3 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_ok_i | input | 1 | One-cycle strobe per correctly received frame |
| cpu_sel_i | input | 1 | Register access strobe |
| cpu_wr_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | 2 | Register address (0 flags, 1 enables, 2 foreground slot) |
| cpu_wdata_i | input | 8 | Write data |
| cpu_rdata_o | output | 8 | Read data, combinational |
| cpu_err_o | output | 1 | Access error on an empty foreground read |
| init_req_i | input | 1 | Initialization-mode request |
| init_ack_i | input | 1 | Initialization-mode acknowledge |
| irq_rx_o | output | 1 | Receive interrupt level |
| irq_err_o | output | 1 | Error (overrun) interrupt level |

## Verification
The bench uses the default DEPTH of 5. This keeps a full sweep cheap: every burst length from 0 to 7 frames covers the empty, partial, exactly-full and overrun cases, and each burst is drained one release at a time with the slot index checked against a ring count. With the flags held set, all 256 enable values are written and read back, and both interrupt outputs are compared for each value. The three combinations of the initialization inputs are stepped through, as are a release in the same cycle as an arrival and an overrun clear in the same cycle as a new overrun.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
    localparam int REG_W  = 8;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADDR_FLAG = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_IEN  = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_FG   = 2'd2;

    localparam int FLG_FULL = 0;
    localparam int FLG_OVR  = 1;

    localparam int IEN_FULL = 0;
    localparam int IEN_OVR  = 1;

    // state-field enables survive initialization mode
    localparam logic [REG_W-1:0] IEN_KEEP_MASK = 8'h3C;
    localparam int FG_VALID_BIT = REG_W - 1;
endpackage

// File: rtl/rxs_queue_ctl.sv
module rxs_queue_ctl #(
    parameter int DEPTH = 5,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_i,
    input  logic             release_i,
    input  logic             ovr_clr_i,
    output logic             full_o,
    output logic             ovr_o,
    output logic [PTR_W-1:0] head_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             full;
        logic             ovr;
        logic [PTR_W-1:0] head;
        logic [PTR_W-1:0] tail;
    } qstate_t;

    qstate_t st_d, st_q;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    logic rel, accept, drop;

    always_comb begin
        st_d   = st_q;
        rel    = release_i && st_q.full;
        accept = frame_i && ((st_q.cnt < CNT_W'(DEPTH)) || rel);
        drop   = frame_i && !accept;

        if (rel) begin
            st_d.full = 1'b0;
            st_d.head = ptr_inc(st_q.head);
        end
        if (accept) begin
            st_d.tail = ptr_inc(st_q.tail);
        end
        st_d.cnt = st_q.cnt + CNT_W'(accept) - CNT_W'(rel);

        // move the oldest waiting entry into the foreground slot
        if (!st_q.full && (st_q.cnt != '0)) begin
            st_d.full = 1'b1;
        end

        if (ovr_clr_i) begin
            st_d.ovr = 1'b0;
        end
        if (drop) begin
            st_d.ovr = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign full_o = st_q.full;
    assign ovr_o  = st_q.ovr;
    assign head_o = st_q.head;

    AST_FULL_NEEDS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.full |-> (st_q.cnt != '0)); // R1
    AST_FG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.full && !release_i) |=> (st_q.full && $stable(st_q.head))); // R2
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(DEPTH)); // R4
    AST_PTR_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        ((int'(st_q.tail) - int'(st_q.head) + DEPTH) % DEPTH) == (int'(st_q.cnt) % DEPTH)); // R4
    AST_OVR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_i && st_q.cnt == CNT_W'(DEPTH) && !(release_i && st_q.full))
        |=> (st_q.ovr && st_q.cnt == CNT_W'(DEPTH))); // R4
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ovr && !ovr_clr_i) |=> st_q.ovr); // R5
endmodule

// File: rtl/rxs_ien_reg.sv
module rxs_ien_reg
    import rxs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_req_i,
    input  logic             init_ack_i,
    input  logic             wr_i,
    input  logic [REG_W-1:0] wdata_i,
    output logic [REG_W-1:0] ien_o
);
    logic [REG_W-1:0] ien_d, ien_q;
    logic             init_on, open;

    always_comb begin
        init_on = init_req_i && init_ack_i;
        open    = !init_req_i && !init_ack_i;
        ien_d   = ien_q;
        if (init_on) begin
            ien_d = ien_q & IEN_KEEP_MASK;
        end else if (open && wr_i) begin
            ien_d = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ien_q <= '0;
        end else begin
            ien_q <= ien_d;
        end
    end

    assign ien_o = ien_q;

    AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (init_req_i && init_ack_i) |=> ((ien_q & ~IEN_KEEP_MASK) == '0)); // R9
    AST_INIT_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (init_req_i && init_ack_i) |=> $stable(ien_q & IEN_KEEP_MASK)); // R9
    AST_TRANSIT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (init_req_i ^ init_ack_i) |=> $stable(ien_q)); // R10
endmodule

// File: rtl/can_rx_flag_unit.sv
module can_rx_flag_unit
    import rxs_pkg::*;
#(
    parameter int DEPTH = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_ok_i,
    input  logic              cpu_sel_i,
    input  logic              cpu_wr_i,
    input  logic [ADDR_W-1:0] cpu_addr_i,
    input  logic [REG_W-1:0]  cpu_wdata_i,
    output logic [REG_W-1:0]  cpu_rdata_o,
    output logic              cpu_err_o,
    input  logic              init_req_i,
    input  logic              init_ack_i,
    output logic              irq_rx_o,
    output logic              irq_err_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic             flag_wr, ien_wr, fg_rd;
    logic             full, ovr;
    logic [PTR_W-1:0] head;
    logic [REG_W-1:0] ien;

    assign flag_wr = cpu_sel_i && cpu_wr_i && (cpu_addr_i == ADDR_FLAG);
    assign ien_wr  = cpu_sel_i && cpu_wr_i && (cpu_addr_i == ADDR_IEN);
    assign fg_rd   = cpu_sel_i && !cpu_wr_i && (cpu_addr_i == ADDR_FG);

    rxs_queue_ctl #(.DEPTH(DEPTH)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_i   (frame_ok_i),
        .release_i (flag_wr && cpu_wdata_i[FLG_FULL]),
        .ovr_clr_i (flag_wr && cpu_wdata_i[FLG_OVR]),
        .full_o    (full),
        .ovr_o     (ovr),
        .head_o    (head)
    );

    rxs_ien_reg u_ien (
        .clk        (clk),
        .rst_n      (rst_n),
        .init_req_i (init_req_i),
        .init_ack_i (init_ack_i),
        .wr_i       (ien_wr),
        .wdata_i    (cpu_wdata_i),
        .ien_o      (ien)
    );

    always_comb begin
        cpu_rdata_o = '0;
        unique case (cpu_addr_i)
            ADDR_FLAG: begin
                cpu_rdata_o[FLG_FULL] = full;
                cpu_rdata_o[FLG_OVR]  = ovr;
            end
            ADDR_IEN: cpu_rdata_o = ien;
            ADDR_FG: begin
                if (full) begin
                    cpu_rdata_o[FG_VALID_BIT] = 1'b1;
                    cpu_rdata_o[PTR_W-1:0]    = head;
                end
            end
            default: cpu_rdata_o = '0;
        endcase
    end

    assign cpu_err_o = fg_rd && !full;
    assign irq_rx_o  = full && ien[IEN_FULL];
    assign irq_err_o = ovr && ien[IEN_OVR];
endmodule

// File: tb/can_rx_flag_unit_bench.sv
`timescale 1ns/1ps
module can_rx_flag_unit_bench;
    localparam int DEPTH = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame = 1'b0;
    logic       sel = 1'b0;
    logic       wr = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       req = 1'b0;
    logic       ack = 1'b0;
    logic [7:0] rdata;
    logic       err;
    logic       irq_rx;
    logic       irq_err;

    int checks = 0;
    int errors = 0;
    int rel_total = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    can_rx_flag_unit #(.DEPTH(DEPTH)) u_can_rx_flag_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_ok_i  (frame),
        .cpu_sel_i   (sel),
        .cpu_wr_i    (wr),
        .cpu_addr_i  (addr),
        .cpu_wdata_i (wdata),
        .cpu_rdata_o (rdata),
        .cpu_err_o   (err),
        .init_req_i  (req),
        .init_ack_i  (ack),
        .irq_rx_o    (irq_rx),
        .irq_err_o   (irq_err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic send_frame();
        frame = 1'b1;
        @(negedge clk);
        frame = 1'b0;
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic frame_and_wr(input logic [1:0] a, input logic [7:0] d);
        frame = 1'b1; sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        frame = 1'b0; sel = 1'b0; wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int d, output int e);
        sel = 1'b1; wr = 1'b0; addr = a;
        #1;
        d = int'(rdata);
        e = int'(err);
        sel = 1'b0;
        @(negedge clk);
    endtask

    task automatic drain(input int cnt);
        int d, e;
        for (int i = 0; i < cnt; i++) begin
            rd(2'd2, d, e);
            chk("R11 slot", d, 'h80 | (rel_total % DEPTH));
            chk("R11 err", e, 0);
            wr_reg(2'd0, 8'h01);
            rel_total++;
            rd(2'd0, d, e);
            chk("R3 cleared", d & 1, 0);
            rd(2'd0, d, e);
            chk("R3 next shift", d & 1, (i + 1 < cnt) ? 1 : 0);
        end
        rd(2'd2, d, e);
        chk("R11 empty data", d, 0);
        chk("R11 empty err", e, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int d, e, d0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // reset state
        rd(2'd0, d, e); chk("R12 reset flags", d, 0);
        rd(2'd1, d, e); chk("R8 reset enables", d, 0);
        rd(2'd2, d, e); chk("R11 reset slot", d, 0); chk("R11 reset err", e, 1);
        rd(2'd3, d, e); chk("R12 unused addr", d, 0);
        chk("R6 reset irq", int'(irq_rx), 0);
        chk("R7 reset irq", int'(irq_err), 0);

        // burst sweep over all fill levels up to beyond overrun
        for (int n = 0; n <= DEPTH + 2; n++) begin
            repeat (n) send_frame();
            tick(); tick();
            rd(2'd0, d, e);
            chk("R1 full flag", d & 1, (n > 0) ? 1 : 0);
            chk("R4 overrun", (d >> 1) & 1, (n > DEPTH) ? 1 : 0);
            chk("R12 upper bits", d >> 2, 0);
            if (n > 0) begin
                rd(2'd2, d0, e);
                repeat (3) tick();
                rd(2'd2, d, e);
                chk("R2 slot held", d, d0);
                wr_reg(2'd0, 8'h00);
                rd(2'd0, d, e);
                chk("R3 zero write", d & 1, 1);
            end
            drain((n > DEPTH) ? DEPTH : n);
            wr_reg(2'd0, 8'h02);
            rd(2'd0, d, e);
            chk("R5 overrun cleared", d, 0);
        end

        // arrival in the same cycle as a release while full
        repeat (DEPTH) send_frame();
        tick();
        frame_and_wr(2'd0, 8'h01);
        rel_total++;
        rd(2'd0, d, e);
        chk("R4 release and arrival", (d >> 1) & 1, 0);
        rd(2'd0, d, e);
        chk("R1 refill", d & 1, 1);
        drain(DEPTH);

        // overrun clear colliding with a new overrun
        repeat (DEPTH + 1) send_frame();
        tick();
        frame_and_wr(2'd0, 8'h02);
        rd(2'd0, d, e);
        chk("R5 set wins", (d >> 1) & 1, 1);

        // enable sweep with both flags set
        for (int v = 0; v < 256; v++) begin
            wr_reg(2'd1, 8'(v));
            rd(2'd1, d, e);
            chk("R8 readback", d, v);
            chk("R6 irq_rx", int'(irq_rx), v & 1);
            chk("R7 irq_err", int'(irq_err), (v >> 1) & 1);
        end
        wr_reg(2'd0, 8'h02);
        chk("R7 irq_err after clear", int'(irq_err), 0);
        chk("R6 irq_rx still set", int'(irq_rx), 1);
        drain(DEPTH);
        chk("R6 irq_rx after drain", int'(irq_rx), 0);

        // initialization-mode handling
        wr_reg(2'd1, 8'hFF);
        req = 1'b1;
        tick();
        wr_reg(2'd1, 8'h00);
        rd(2'd1, d, e);
        chk("R10 request only", d, 'hFF);
        ack = 1'b1;
        tick();
        rd(2'd1, d, e);
        chk("R9 held", d, 'h3C);
        wr_reg(2'd1, 8'hFF);
        rd(2'd1, d, e);
        chk("R9 write ignored", d, 'h3C);
        req = 1'b0;
        tick();
        wr_reg(2'd1, 8'h00);
        rd(2'd1, d, e);
        chk("R10 ack only", d, 'h3C);
        ack = 1'b0;
        tick();
        wr_reg(2'd1, 8'hC3);
        rd(2'd1, d, e);
        chk("R8 writable again", d, 'hC3);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule